// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers interrupt events for a small 8-bit processor core and turns them into a high-priority request, a low-priority request and a wake-up signal. Six sources feed it: four asynchronous external pins, each with a selectable active edge; a single-cycle timer wrap pulse from a counter outside the block; and a change detector on the upper nibble of an 8-bit input port. Each source owns a sticky flag and an enable bit. Every source except external pin 0 also owns a priority bit. Pin 0 is always high priority.

Software reaches all state through a four-register read/write port. A flag that was raised stays raised until software writes 0 to its bit. If hardware raises a flag in the same cycle that software writes to the flag register, the hardware event wins. Whenever the core is asleep, any enabled pending flag asserts the wake output, whatever the global enable says. The two request outputs only assert when the global enable is set, which is what lets the core branch to its vector after it wakes.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every flag, every enable and the global enable read 0. Register 2 reads 0x3F and register 3 reads 0x0F. irq_hi, irq_lo and wake are low.
- R2: External pin n (n = 0..3) goes through a two-flop synchronizer. A rising edge sets flag bit n when edge-select bit n (register 3) is 1, and a falling edge sets it when that bit is 0. The opposite edge leaves the flag unchanged. The flag is readable by the third rising clock edge after the pin changes.
- R3: The flag register is register 0: bits 0-3 hold pins 0-3, bit 4 holds the timer and bit 5 holds the port change. Writing the register loads the written bits, so writing 0 clears a flag and writing 1 sets it. A flag keeps its value when no write and no event occurs.
- R4: Register 1 holds the source enables in bits 5:0, with the same order as the flags. A flag still sets while its enable is 0, but a disabled flag produces no request and no wake.
- R5: Register 2 holds the priority bits 5:1 (1 = high, 0 = low). Bit 0 always reads 1 and writes to it are ignored, so pin 0 always drives irq_hi.
- R6: A timer wrap pulse (tmr_wrap high for one cycle) sets flag bit 4 at the next rising edge.
- R7: A change in the value of port_in bits 7:4 sets flag bit 5 by the third rising edge after the change. Changes on bits 3:0 leave the flag unchanged.
- R8: wake is asserted exactly when sleep is high and at least one flag is both set and enabled. The global enable has no effect on wake.
- R9: irq_hi is the global enable (register 1 bit 7) ANDed with the presence of any enabled set flag of high priority. irq_lo is the same for low priority.
- R10: When a write to register 0 falls in the same cycle as a hardware event on a source, that source's flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| port_in | input | 8 | Input port; only bits 7:4 are watched |
| tmr_wrap | input | 1 | One-cycle timer wrap pulse |
| sleep | input | 1 | Core is in sleep |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| wake | output | 1 | Wake-up request |

## Verification
Two events can land in the same clock cycle: a software write to the flag register, and a hardware event that sets a flag. To provoke this, the bench drives a timer wrap pulse on the same cycle as a write of zero to register 0. It then reads the register back. The timer flag must be set, and the flags that had no event must be cleared. The bench also picks random combinations of flags, enables, priorities, global enable and sleep, and compares all three outputs against values it computes for itself.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ext_pin,
  input  logic [7:0] port_in,
  input  logic       tmr_wrap,
  input  logic       sleep,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_hi,
  output logic       irq_lo,
  output logic       wake
);
  logic [3:0] pin_s1, pin_s2, pin_d;
  logic [3:0] nib_s1, nib_s2, nib_d;
  logic [5:0] flags, en;
  logic [5:1] prio;
  logic [3:0] edge_sel;
  logic       gie;

  logic [3:0] pin_hit;
  logic [5:0] hw_set, pend, prio_eff;

  assign pin_hit  = (pin_s2 & ~pin_d & edge_sel) | (~pin_s2 & pin_d & ~edge_sel);
  assign hw_set   = {(nib_s2 != nib_d), tmr_wrap, pin_hit};
  assign pend     = flags & en;
  assign prio_eff = {prio, 1'b1};

  assign irq_hi = gie & |(pend & prio_eff);
  assign irq_lo = gie & |(pend & ~prio_eff);
  assign wake   = sleep & |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= '0; pin_s2 <= '0; pin_d <= '0;
      nib_s1 <= '0; nib_s2 <= '0; nib_d <= '0;
    end else begin
      pin_s1 <= ext_pin;     pin_s2 <= pin_s1; pin_d <= pin_s2;
      nib_s1 <= port_in[7:4]; nib_s2 <= nib_s1; nib_d <= nib_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      en       <= '0;
      gie      <= 1'b0;
      prio     <= '1;
      edge_sel <= '1;
    end else begin
      flags <= ((reg_we && reg_addr == 2'd0) ? reg_wdata[5:0] : flags) | hw_set;
      if (reg_we) begin
        case (reg_addr)
          2'd1: begin en <= reg_wdata[5:0]; gie <= reg_wdata[7]; end
          2'd2: prio <= reg_wdata[5:1];
          2'd3: edge_sel <= reg_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {2'b00, flags};
      2'd1:    reg_rdata = {gie, 1'b0, en};
      2'd2:    reg_rdata = {2'b00, prio_eff};
      default: reg_rdata = {4'h0, edge_sel};
    endcase
  end
endmodule

module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       tmr_wrap,
  input logic       sleep,
  input logic [5:0] flags,
  input logic [5:0] en,
  input logic       gie,
  input logic       irq_hi,
  input logic       irq_lo,
  input logic       wake
);
  logic flag_wr;
  assign flag_wr = reg_we && (reg_addr == 2'd0);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flags & $past(flags)) == $past(flags)));

  assert_tmr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> flags[4]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && tmr_wrap) |=> flags[4]);

  assert_wake_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && |(flags & en)) |-> wake);

  assert_wake_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> !wake);

  assert_gie_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!irq_hi && !irq_lo));

  assert_pin0_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && flags[0] && en[0]) |-> irq_hi);

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en) == 6'd0) |-> (!irq_hi && !irq_lo && !wake));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .tmr_wrap(tmr_wrap), .sleep(sleep), .flags(flags), .en(en), .gie(gie),
  .irq_hi(irq_hi), .irq_lo(irq_lo), .wake(wake)
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic [3:0] ext_pin = 0;
  logic [7:0] port_in = 0;
  logic       tmr_wrap = 0, sleep = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq_hi, irq_lo, wake;

  int errors = 0, checks = 0;
  bit done = 0;

  irq_flag_ctrl u_dut (.*);

  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2:0] model(logic [5:0] fl, logic [5:0] en,
                                       logic [5:1] pr, logic g, logic s);
    logic [5:0] p, pe;
    p = fl & en; pe = {pr, 1'b1};
    return {g & |(p & pe), g & |(p & ~pe), s & |p};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1234));
    wait_cyc(3); rst_n = 1;

    rd(0, d); check("R1 flags", d, 8'h00);
    rd(1, d); check("R1 enables", d, 8'h00);
    rd(2, d); check("R1 prio", d, 8'h3F);
    rd(3, d); check("R1 edge", d, 8'h0F);
    check("R1 outputs", {irq_hi, irq_lo, wake}, 0);

    ext_pin[1] = 1; wait_cyc(4); ext_pin[1] = 0; wait_cyc(4);
    rd(0, d); check("R2 rising pin1", d, 8'h02);
    wr(0, 0);
    wr(3, 8'h0E);
    ext_pin[0] = 1; wait_cyc(4);
    rd(0, d); check("R2 rising ignored in falling mode", d, 8'h00);
    ext_pin[0] = 0; wait_cyc(4);
    rd(0, d); check("R2 falling pin0", d, 8'h01);
    wait_cyc(3);
    rd(0, d); check("R3 flag stays set", d, 8'h01);
    wr(0, 0);
    rd(0, d); check("R3 write clears", d, 8'h00);
    wr(0, 8'h24);
    rd(0, d); check("R3 write sets", d, 8'h24);
    wr(0, 0);

    @(negedge clk); tmr_wrap = 1; @(negedge clk); tmr_wrap = 0;
    rd(0, d); check("R6 timer wrap", d, 8'h10);
    wr(0, 0);

    port_in = 8'h0F; wait_cyc(5);
    rd(0, d); check("R7 low nibble ignored", d, 8'h00);
    port_in = 8'h4F; wait_cyc(5);
    rd(0, d); check("R7 upper nibble change", d, 8'h20);

    wr(0, 8'h0F);
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 0; tmr_wrap = 1;
    @(negedge clk); reg_we = 0; tmr_wrap = 0;
    rd(0, d); check("R10 set wins over clear", d, 8'h10);

    wr(0, 8'h3F); wr(1, 8'h80); sleep = 1; wait_cyc(1);
    check("R4 disabled sources quiet", {irq_hi, irq_lo, wake}, 0);

    wr(2, 8'h00);
    rd(2, d); check("R5 pin0 prio fixed", d, 8'h01);
    wr(0, 8'h01); wr(1, 8'h81); wait_cyc(1);
    check("R5 pin0 high", {irq_hi, irq_lo}, 2'b10);
    wr(1, 8'h01); wait_cyc(1);
    check("R8 wake without gie", {irq_hi, irq_lo, wake}, 3'b001);
    check("R9 gie gates requests", {irq_hi, irq_lo}, 0);

    for (int i = 0; i < 200; i++) begin
      logic [5:0] fl, en; logic [5:1] pr; logic g, s;
      fl = 6'($urandom); en = 6'($urandom); pr = 5'($urandom);
      g = 1'($urandom); s = 1'($urandom);
      if (i % 10 == 0) en = 0;
      wr(0, {2'b00, fl}); wr(1, {g, 1'b0, en}); wr(2, {2'b00, pr, 1'b0});
      sleep = s; wait_cyc(1);
      check("R4 R5 R8 R9 random routing", {irq_hi, irq_lo, wake},
            model(fl, en, pr, g, s));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule